// File: doc/BRIEF.md
# Symmetric 3D Stencil Wave-Field Update Datapath

This block is the arithmetic core of a finite-difference wave-propagation step. Each accepted input bundle carries one centre value of the current field, its 24 neighbours along the three axes, the value of the previous time step at the same point, and a velocity value. From these it produces one updated field value. The stencil is a radius-4 star. Along each axis, the two neighbours at the same distance are added first and then multiplied by one weight, so every axis is a folded symmetric FIR. The stencil sum is then fed into a second-order leapfrog time update.

Arithmetic is signed fixed point with 8 integer bits and 16 fraction bits, so no floating-point units are needed. The weights, the centre coefficient and the time step are held in registers, loaded one at a time through a small write port while the pipeline is empty. The datapath accepts a bundle every cycle and returns each result after a fixed latency. It has no output backpressure. An upstream fetch unit supplies the operands and a downstream sink takes the results.

Top module: `stc_wave_update`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, in_ready is 1, and all 14 coefficients are 0. With zero coefficients a result equals sat(2·centre − previous).
- R2: A write with cfg_we high stores cfg_val into the coefficient selected by cfg_idx. Index a·4+(l−1) is the weight for distance l (1..4) on axis a (0..2). Index 12 is the centre coefficient c0 and index 13 is the time step dt. Writes to indices 14 and 15 change nothing. Coefficient writes occur only while no bundle is in flight.
- R3: in_ready is low in every cycle in which cfg_we is high, and a bundle offered in such a cycle produces no result.
- R4: in_nbr holds 24 fields of 24 bits. Slot s = a·8 + 2·(l−1) + k occupies bits [s·24 +: 24], where a is the axis, l is the distance and k is 0 for the negative side and 1 for the positive side. Each pair of slots at one distance on one axis is summed with saturation before its multiply.
- R5: A product of two Q8.16 values is the full product shifted right arithmetically by 16 bits (truncation toward minus infinity), then saturated to 24 bits.
- R6: Each axis sum is the exact sum of its 4 weighted pairs, saturated once. The stencil value is the exact sum of the three saturated axis sums and c0·centre, saturated once.
- R7: The result is sat(stencil + (vel·dt)² + 2·centre − previous). The sum is formed exactly and saturated once to the range −2^23 to 2^23−1.
- R8: A bundle accepted on a rising edge shows on out_data with out_valid high after the fourth rising edge that follows it. One bundle per cycle is sustained.
- R9: out_valid is high only for bundles that were accepted. Idle cycles and refused offers produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | 4 | Coefficient index |
| cfg_val | input | 24 | Coefficient value, Q8.16 |
| in_valid | input | 1 | Input bundle present |
| in_ready | output | 1 | Bundle accepted when high together with in_valid |
| in_ctr | input | 24 | Centre value of the current field |
| in_nbr | input | 576 | 24 neighbour values, slot layout per R4 |
| in_prev | input | 24 | Previous time-step value at the centre |
| in_vel | input | 24 | Velocity value at the centre |
| out_valid | output | 1 | Result valid |
| out_data | output | 24 | Updated field value, Q8.16 |

## Verification
The assertions assume that a coefficient is never rewritten while a bundle is still in the pipeline, because results would otherwise mix two coefficient sets. The stimulus meets this by waiting until every outstanding result has come out before each burst of coefficient writes. It offers a bundle during a write only to check that the bundle is refused. The pair-sign checks assume that operands are known values from the first cycle after reset, so the stimulus drives every data input from time zero.

// File: rtl/stc_pkg.sv
package stc_pkg;
   localparam int STC_W_DEF    = 24;
   localparam int STC_FRAC_DEF = 16;
   localparam int STC_RAD_DEF  = 4;
   localparam int STC_AXES     = 3;

   // clamp a wide value into a signed w-bit range
   function automatic longint sat_to(input longint v, input int w);
      longint hi;
      longint lo;
      hi = (longint'(1) <<< (w - 1)) - 1;
      lo = -(longint'(1) <<< (w - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   // fixed-point product: floor shift by f, then clamp to w bits
   function automatic longint qmul(input longint a, input longint b,
                                   input int w, input int f);
      return sat_to((a * b) >>> f, w);
   endfunction
endpackage

// File: rtl/stc_pair_fold.sv
module stc_pair_fold import stc_pkg::*; #(
   parameter int W = STC_W_DEF
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   output logic [W-1:0] sum_q
);
   always_ff @(posedge clk) begin
      sum_q <= W'(sat_to(longint'($signed(lo_i)) + longint'($signed(hi_i)), W));
   end

   AST_PAIR_NONNEG: assert property (@(posedge clk) disable iff (rst)
      ($signed(lo_i) >= 0 && $signed(hi_i) >= 0) |=> ($signed(sum_q) >= 0)); // R4
   AST_PAIR_NEG: assert property (@(posedge clk) disable iff (rst)
      ($signed(lo_i) < 0 && $signed(hi_i) < 0) |=> ($signed(sum_q) < 0)); // R4
endmodule

// File: rtl/stc_axis_mac.sv
module stc_axis_mac import stc_pkg::*; #(
   parameter int W    = STC_W_DEF,
   parameter int FRAC = STC_FRAC_DEF,
   parameter int RAD  = STC_RAD_DEF
) (
   input  logic             clk,
   input  logic [RAD*W-1:0] pairs_i,
   input  logic [RAD*W-1:0] wts_i,
   output logic [W-1:0]     sum_q
);
   logic [W-1:0] prod_q [RAD];
   longint       acc;

   always_ff @(posedge clk) begin
      for (int l = 0; l < RAD; l++) begin
         prod_q[l] <= W'(qmul(longint'($signed(pairs_i[l*W +: W])),
                              longint'($signed(wts_i[l*W +: W])), W, FRAC));
      end
   end

   always_comb begin
      acc = 0;
      for (int l = 0; l < RAD; l++) acc += longint'($signed(prod_q[l]));
   end

   always_ff @(posedge clk) begin
      sum_q <= W'(sat_to(acc, W));
   end
endmodule

// File: rtl/stc_time_step.sv
module stc_time_step import stc_pkg::*; #(
   parameter int W    = STC_W_DEF,
   parameter int FRAC = STC_FRAC_DEF
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] ctr_i,
   input  logic [W-1:0] prev_i,
   input  logic [W-1:0] vel_i,
   input  logic [W-1:0] c0_i,
   input  logic [W-1:0] dt_i,
   input  logic [W-1:0] ax_i,
   input  logic [W-1:0] ay_i,
   input  logic [W-1:0] az_i,
   output logic [W-1:0] out_q
);
   logic [W-1:0] cterm2, vd2, ctr2, prev2;
   logic [W-1:0] cterm3, vsq3, ctr3, prev3;
   logic [W-1:0] sten4, vsq4, ctr4, prev4;
   longint       sten_sum, step_sum;

   always_ff @(posedge clk) begin
      cterm2 <= W'(qmul(longint'($signed(ctr_i)), longint'($signed(c0_i)), W, FRAC));
      vd2    <= W'(qmul(longint'($signed(vel_i)), longint'($signed(dt_i)), W, FRAC));
      ctr2   <= ctr_i;
      prev2  <= prev_i;
      cterm3 <= cterm2;
      vsq3   <= W'(qmul(longint'($signed(vd2)), longint'($signed(vd2)), W, FRAC));
      ctr3   <= ctr2;
      prev3  <= prev2;
      sten4  <= W'(sat_to(sten_sum, W));
      vsq4   <= vsq3;
      ctr4   <= ctr3;
      prev4  <= prev3;
   end

   always_comb begin
      sten_sum = longint'($signed(ax_i)) + longint'($signed(ay_i))
               + longint'($signed(az_i)) + longint'($signed(cterm3));
      step_sum = longint'($signed(sten4)) + longint'($signed(vsq4))
               + 2 * longint'($signed(ctr4)) - longint'($signed(prev4));
   end

   always_ff @(posedge clk) begin
      if (rst) out_q <= '0;
      else     out_q <= W'(sat_to(step_sum, W));
   end
endmodule

// File: rtl/stc_wave_update.sv
module stc_wave_update import stc_pkg::*; #(
   parameter  int W     = STC_W_DEF,
   parameter  int FRAC  = STC_FRAC_DEF,
   parameter  int RAD   = STC_RAD_DEF,
   localparam int NCOEF = STC_AXES * RAD + 2,
   localparam int IW    = $clog2(NCOEF),
   localparam int NSLOT = 2 * STC_AXES * RAD
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_we,
   input  logic [IW-1:0]      cfg_idx,
   input  logic [W-1:0]       cfg_val,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [W-1:0]       in_ctr,
   input  logic [NSLOT*W-1:0] in_nbr,
   input  logic [W-1:0]       in_prev,
   input  logic [W-1:0]       in_vel,
   output logic               out_valid,
   output logic [W-1:0]       out_data
);
   localparam int LAT    = 5;
   localparam int IDX_C0 = STC_AXES * RAD;
   localparam int IDX_DT = STC_AXES * RAD + 1;

   if (W < 4 || W > 31) begin : g_bad_width
      $error("stc_wave_update: W must lie in 4..31");
   end
   if (FRAC >= W || FRAC < 1) begin : g_bad_frac
      $error("stc_wave_update: FRAC must lie in 1..W-1");
   end
   if (RAD < 1) begin : g_bad_rad
      $error("stc_wave_update: RAD must be at least 1");
   end

   logic signed [W-1:0] coef [NCOEF];
   logic [LAT-1:0]      vp;
   logic                acc;
   logic [W-1:0]        ctr1, prev1, vel1;

   assign in_ready  = ~cfg_we;
   assign acc       = in_valid & in_ready & ~rst;
   assign out_valid = vp[LAT-1];

   for (genvar k = 0; k < NCOEF; k++) begin : g_coef
      always_ff @(posedge clk) begin
         if (rst)                             coef[k] <= '0;
         else if (cfg_we && cfg_idx == IW'(k)) coef[k] <= cfg_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) vp <= '0;
      else     vp <= {vp[LAT-2:0], acc};
   end

   always_ff @(posedge clk) begin
      ctr1  <= in_ctr;
      prev1 <= in_prev;
      vel1  <= in_vel;
   end

   for (genvar a = 0; a < STC_AXES; a++) begin : g_axis
      logic [RAD*W-1:0] pair_bus;
      logic [RAD*W-1:0] wt_bus;
      logic [W-1:0]     axis_sum;
      for (genvar l = 0; l < RAD; l++) begin : g_tap
         stc_pair_fold #(.W(W)) u_fold (
            .clk   (clk),
            .rst   (rst),
            .lo_i  (in_nbr[(a*2*RAD + 2*l)*W +: W]),
            .hi_i  (in_nbr[(a*2*RAD + 2*l + 1)*W +: W]),
            .sum_q (pair_bus[l*W +: W])
         );
         assign wt_bus[l*W +: W] = coef[a*RAD + l];
      end
      stc_axis_mac #(.W(W), .FRAC(FRAC), .RAD(RAD)) u_mac (
         .clk     (clk),
         .pairs_i (pair_bus),
         .wts_i   (wt_bus),
         .sum_q   (axis_sum)
      );
   end

   stc_time_step #(.W(W), .FRAC(FRAC)) u_step (
      .clk    (clk),
      .rst    (rst),
      .ctr_i  (ctr1),
      .prev_i (prev1),
      .vel_i  (vel1),
      .c0_i   (coef[IDX_C0]),
      .dt_i   (coef[IDX_DT]),
      .ax_i   (g_axis[0].axis_sum),
      .ay_i   (g_axis[1].axis_sum),
      .az_i   (g_axis[2].axis_sum),
      .out_q  (out_data)
   );

   AST_CFG_IDLE: assert property (@(posedge clk) disable iff (rst)
      cfg_we |-> (vp == '0)); // R2
   AST_CFG_STALL: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && in_valid) |=> !vp[0]); // R3
   AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
      $past(acc, LAT) |-> out_valid); // R8
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(acc, LAT)); // R9
endmodule

// File: tb/sim_stc_wave_update.sv
module sim_stc_wave_update;
   localparam int CLK_PERIOD = 10;
   localparam int W     = 24;
   localparam int FR    = 16;
   localparam int NS    = 24;
   localparam int NC    = 14;
   localparam longint MAXV = 8388607;
   localparam longint MINV = -8388608;

   logic            clk = 1'b0;
   logic            rst;
   logic            cfg_we;
   logic [3:0]      cfg_idx;
   logic [W-1:0]    cfg_val;
   logic            in_valid;
   logic            in_ready;
   logic [W-1:0]    in_ctr;
   logic [NS*W-1:0] in_nbr;
   logic [W-1:0]    in_prev;
   logic [W-1:0]    in_vel;
   logic            out_valid;
   logic [W-1:0]    out_data;

   int     total = 0;
   int     bad   = 0;
   int     ncyc  = 0;
   bit     done  = 0;
   string  cur_req;
   longint mc [16];
   longint nbv [NS];
   longint exp_q [$];
   int     due_q [$];
   string  tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   stc_wave_update u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
      .in_valid(in_valid), .in_ready(in_ready), .in_ctr(in_ctr), .in_nbr(in_nbr),
      .in_prev(in_prev), .in_vel(in_vel), .out_valid(out_valid), .out_data(out_data)
   );

   function automatic longint clampw(longint v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return v;
   endfunction

   function automatic longint fmul(longint a, longint b);
      return clampw((a * b) >>> FR);
   endfunction

   function automatic longint model(longint ctr, longint prev, longint vel);
      longint stc, ax, pr, vd;
      stc = 0;
      for (int a = 0; a < 3; a++) begin
         ax = 0;
         for (int l = 0; l < 4; l++) begin
            pr = clampw(nbv[a*8 + 2*l] + nbv[a*8 + 2*l + 1]);
            ax += fmul(pr, mc[a*4 + l]);
         end
         stc += clampw(ax);
      end
      stc = clampw(stc + fmul(ctr, mc[12]));
      vd  = fmul(vel, mc[13]);
      return clampw(stc + fmul(vd, vd) + 2 * ctr - prev);
   endfunction

   function automatic longint rnd(int mb);
      return longint'($urandom_range(0, (1 << (mb + 1)) - 1)) - (longint'(1) << mb);
   endfunction

   task automatic chk(string tag, longint got, longint expv);
      total++;
      if (got != expv) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, expv);
      end
   endtask

   always @(posedge clk) ncyc <= ncyc + 1;

   // reference comparison, every cycle
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               chk("R9 unexpected out_valid", 1, 0);
            end else begin
               chk(tag_q[0], longint'($signed(out_data)), exp_q[0]);
               chk("R8 result cycle", ncyc, due_q[0]);
               void'(exp_q.pop_front());
               void'(due_q.pop_front());
               void'(tag_q.pop_front());
            end
         end else if (due_q.size() > 0 && due_q[0] <= ncyc) begin
            chk("R8 missing result", 0, 1);
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
            void'(tag_q.pop_front());
         end
         if (in_valid && in_ready) begin
            for (int s = 0; s < NS; s++) nbv[s] = longint'($signed(in_nbr[s*W +: W]));
            exp_q.push_back(model(longint'($signed(in_ctr)), longint'($signed(in_prev)),
                                  longint'($signed(in_vel))));
            due_q.push_back(ncyc + 5);
            tag_q.push_back(cur_req);
         end
         if (cfg_we && cfg_idx < 4'd14) mc[cfg_idx] = longint'($signed(cfg_val));
      end
   end

   task automatic cfg_write(int idx, longint v);
      @(posedge clk); #1;
      in_valid = 0;
      cfg_we   = 1;
      cfg_idx  = 4'(idx);
      cfg_val  = W'(v);
      @(posedge clk); #1;
      cfg_we   = 0;
   endtask

   task automatic drive_rand(int mb);
      @(posedge clk); #1;
      cfg_we = 0;
      in_valid = 1;
      for (int s = 0; s < NS; s++) in_nbr[s*W +: W] = W'(rnd(mb));
      in_ctr  = W'(rnd(mb));
      in_prev = W'(rnd(mb));
      in_vel  = W'(rnd(mb));
   endtask

   task automatic drive_fill(longint nb, longint ctr, longint prev, longint vel);
      @(posedge clk); #1;
      cfg_we = 0;
      in_valid = 1;
      for (int s = 0; s < NS; s++) in_nbr[s*W +: W] = W'(nb);
      in_ctr  = W'(ctr);
      in_prev = W'(prev);
      in_vel  = W'(vel);
   endtask

   task automatic drive_one(int slot, longint v);
      @(posedge clk); #1;
      cfg_we = 0;
      in_valid = 1;
      in_nbr = '0;
      in_nbr[slot*W +: W] = W'(v);
      in_ctr  = '0;
      in_prev = '0;
      in_vel  = '0;
   endtask

   task automatic drain();
      @(posedge clk); #1;
      in_valid = 0;
      repeat (8) @(posedge clk);
      #1;
   endtask

   initial begin
      for (int k = 0; k < 16; k++) mc[k] = 0;
      rst = 1; cfg_we = 0; cfg_idx = '0; cfg_val = '0; in_valid = 0;
      in_ctr = '0; in_nbr = '0; in_prev = '0; in_vel = '0;
      cur_req = "R1";
      repeat (4) @(posedge clk);
      #1 rst = 0;

      @(negedge clk);
      chk("R1 out_valid after reset", out_valid, 0);
      chk("R1 out_data after reset", longint'(out_data), 0);
      chk("R1 in_ready after reset", in_ready, 1);

      // zero coefficients: 2*centre - previous
      cur_req = "R1";
      repeat (4) drive_rand(20);
      cur_req = "R7";
      drive_fill(0, MAXV, MINV, 0);
      drive_fill(0, MINV, MAXV, 0);
      drive_fill(0, 12345, -678, 99999);
      drain();

      // coefficient load, indices 14 and 15 ignored
      cur_req = "R2";
      for (int k = 0; k < 12; k++) cfg_write(k, rnd(15));
      cfg_write(12, rnd(16));
      cfg_write(13, rnd(15));
      cfg_write(14, MAXV);
      cfg_write(15, MAXV);
      repeat (4) drive_rand(18);
      drain();

      // neighbour slot layout
      cur_req = "R4";
      for (int s = 0; s < NS; s += 3) drive_one(s, 300000 + s * 1000);
      drive_one(NS - 1, -250000);
      drain();

      // back-to-back stream
      cur_req = "R8";
      for (int i = 0; i < 40; i++) drive_rand(22);
      drain();

      // offer during coefficient write is refused
      cur_req = "R3";
      @(posedge clk); #1;
      in_valid = 1; cfg_we = 1; cfg_idx = 4'd12; cfg_val = W'(65536);
      @(negedge clk);
      chk("R3 in_ready during write", in_ready, 0);
      @(posedge clk); #1;
      cfg_we = 0; in_valid = 0;
      drain();

      // floor truncation of a negative product
      for (int k = 0; k < NC; k++) cfg_write(k, 0);
      cfg_write(12, 1);
      cur_req = "R5";
      drive_fill(0, -1, 0, 0);
      drive_fill(0, -3, 5, 0);
      drain();
      cfg_write(12, 65536);
      cfg_write(13, MAXV);
      drive_fill(0, -3, 0, 0);
      drive_fill(0, 0, 0, MAXV);
      drive_fill(0, 0, 0, 70000);
      drain();

      // saturation of pairs, products and sums
      for (int k = 0; k < 12; k++) cfg_write(k, MAXV);
      cfg_write(13, 0);
      cur_req = "R6";
      drive_fill(MAXV, 0, 0, 0);
      drive_fill(MINV, 0, 0, 0);
      drive_fill(65536, 1000, 0, 0);
      drive_fill(-65536, -1000, 0, 0);
      drain();

      // idle gap: nothing may appear
      cur_req = "R9";
      repeat (10) @(posedge clk);
      #1;

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL R8 watchdog expired got=%0d exp=%0d", ncyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule